// File: doc/BRIEF.md
# Two-Wire Write-Only Output Code Slave

This block is a receive-only slave on a two-wire serial bus (SCL clock line, SDA data line). It oversamples both lines with a much faster system clock and recognises bus start, repeated start and stop events. It accepts a transaction only when the first byte carries its own 7-bit address and a write direction bit. The address is a fixed five-bit prefix followed by two strap inputs. Each accepted byte is acknowledged by pulling SDA low through an open-drain enable.

After the address, the master sends any number of byte pairs, each a selector byte followed by a value byte. The selector picks one of the channel registers. The value byte is stored there at its acknowledge, and that channel's one-cycle update strobe fires. The outputs feed converters or other consumers that need a stable 8-bit code and a notice when it changes.

Top module: `dac_bus_slave`

## Requirements
- R1: A synchronous reset sets every channel code to 0x00, releases SDA (sda_oe=0) and keeps all update strobes low.
- R2: The slave acknowledges an address byte equal to {0,1,0,1,1,strap_i[1],strap_i[0],0}, sent MSB first. Here the last bit is the direction bit and 0 means write. It then acknowledges every later byte of the same transaction.
- R3: An address byte with a different 7-bit address, or with the direction bit at 1, is not acknowledged. Every following byte up to the next START or STOP is then ignored: no acknowledge, no register change, no strobe.
- R4: sda_oe rises only after a falling SCL edge that ends the eighth bit of a byte. It falls after the next falling SCL edge, or on a START or STOP. It is low while the bits of a byte are being received.
- R5: Bit 0 of the selector byte chooses channel 0 (bit 0 = 0) or channel 1 (bit 0 = 1). Its other bits are ignored. The value byte that follows is written to that channel only.
- R6: Every register write raises the strobe of the written channel for exactly one system clock. Strobes never fire on two channels at once, and a channel code changes only in a cycle where its strobe is high.
- R7: One transaction may carry any number of selector/value pairs, and each pair performs its own write.
- R8: A repeated START restarts the address phase and discards an incomplete pair.
- R9: A STOP after a selector byte and before its value byte discards the selector. The next transaction starts with a fresh selector byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 2 | Low two bits of the slave address |
| sda_oe | output | 1 | Open-drain enable, 1 pulls SDA low |
| chan_code | output | 16 | Channel codes, channel 0 in bits 7:0, channel 1 in bits 15:8 |
| chan_upd | output | 2 | One-cycle update strobe per channel |

## Verification
The timing checks assume a well-formed bus. SDA changes only while SCL is low, except on START and STOP. Each SCL level lasts many system clocks, so the two-flop synchronizer delivers every edge in order. The stimulus holds each SCL half period for 16 system clocks. It moves SDA only in the middle of an SCL low phase, except when it forms a START or STOP. The bench models the line as a wired-AND of the master driver and the slave's enable, so the acknowledge is observed exactly as a master would see it.

// File: rtl/dacs_pkg.sv
package dacs_pkg;

    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_ADDR = 2'd1,
        LK_DATA = 2'd2,
        LK_SKIP = 2'd3
    } link_st_e;

endpackage

// File: rtl/dacs_sync.sv
module dacs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]             prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.prev = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl_o  = s_q.chain[STAGES-1];
    assign rise_o = s_q.chain[STAGES-1] & ~s_q.prev;
    assign fall_o = ~s_q.chain[STAGES-1] & s_q.prev;

endmodule

// File: rtl/dacs_link.sv
module dacs_link
    import dacs_pkg::*;
#(
    parameter int                BYTE_W   = 8,
    parameter int                PREFIX_W = 5,
    parameter logic [PREFIX_W-1:0] PREFIX = 5'b01011,
    parameter int                STRAP_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [STRAP_W-1:0] strap_i,
    output logic              sda_oe,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              frame_rst
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    typedef struct packed {
        link_st_e          st;
        logic [CNT_W-1:0]  bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic              ack;
        logic              oe;
        logic              vld;
        logic              frst;
    } link_t;

    link_t l_d, l_q;
    logic  addr_hit;

    assign addr_hit = (l_q.shreg[BYTE_W-1:1] == {PREFIX, strap_i}) && !l_q.shreg[0];

    always_comb begin
        l_d      = l_q;
        l_d.vld  = 1'b0;
        l_d.frst = 1'b0;
        if (bus_start) begin
            l_d.st     = LK_ADDR;
            l_d.bitcnt = '0;
            l_d.ack    = 1'b0;
            l_d.oe     = 1'b0;
            l_d.frst   = 1'b1;
        end else if (bus_stop) begin
            l_d.st     = LK_IDLE;
            l_d.bitcnt = '0;
            l_d.ack    = 1'b0;
            l_d.oe     = 1'b0;
            l_d.frst   = 1'b1;
        end else if (l_q.st == LK_ADDR || l_q.st == LK_DATA) begin
            if (scl_rise && l_q.bitcnt < LAST_BIT) begin
                l_d.shreg  = {l_q.shreg[BYTE_W-2:0], sda_lvl};
                l_d.bitcnt = l_q.bitcnt + 1'b1;
            end else if (scl_fall && l_q.ack) begin
                l_d.ack    = 1'b0;
                l_d.oe     = 1'b0;
                l_d.bitcnt = '0;
                l_d.st     = LK_DATA;
            end else if (scl_fall && l_q.bitcnt == LAST_BIT) begin
                if (l_q.st == LK_ADDR) begin
                    if (addr_hit) begin
                        l_d.ack = 1'b1;
                        l_d.oe  = 1'b1;
                    end else begin
                        l_d.st = LK_SKIP;
                    end
                end else begin
                    l_d.ack = 1'b1;
                    l_d.oe  = 1'b1;
                    l_d.vld = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l_q <= '{st: LK_IDLE, bitcnt: '0, shreg: '0, ack: 1'b0,
                     oe: 1'b0, vld: 1'b0, frst: 1'b0};
        end else begin
            l_q <= l_d;
        end
    end

    assign sda_oe    = l_q.oe;
    assign byte_vld  = l_q.vld;
    assign byte_data = l_q.shreg;
    assign frame_rst = l_q.frst;

endmodule

// File: rtl/dacs_regs.sv
module dacs_regs #(
    parameter int NUM_CH = 2,
    parameter int CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_rst,
    input  logic                     byte_vld,
    input  logic [CODE_W-1:0]        byte_data,
    output logic [NUM_CH*CODE_W-1:0] chan_code,
    output logic [NUM_CH-1:0]        chan_upd
);

    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic                          have_cmd;
        logic [SEL_W-1:0]              sel;
        logic [NUM_CH-1:0][CODE_W-1:0] codes;
        logic [NUM_CH-1:0]             upd;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.upd = '0;
        if (frame_rst) begin
            r_d.have_cmd = 1'b0;
        end else if (byte_vld) begin
            if (!r_q.have_cmd) begin
                r_d.have_cmd = 1'b1;
                r_d.sel      = byte_data[SEL_W-1:0];
            end else begin
                r_d.have_cmd = 1'b0;
                for (int i = 0; i < NUM_CH; i++) begin
                    if (r_q.sel == SEL_W'(i)) begin
                        r_d.codes[i] = byte_data;
                        r_d.upd[i]   = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_out
            assign chan_code[g*CODE_W +: CODE_W] = r_q.codes[g];
        end
    endgenerate
    assign chan_upd = r_q.upd;

endmodule

// File: rtl/dac_bus_slave.sv
module dac_bus_slave #(
    parameter int                  NUM_CH   = 2,
    parameter int                  CODE_W   = 8,
    parameter int                  SYNC_N   = 2,
    parameter int                  PREFIX_W = 5,
    parameter logic [PREFIX_W-1:0] PREFIX   = 5'b01011,
    parameter int                  STRAP_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     scl_i,
    input  logic                     sda_i,
    input  logic [STRAP_W-1:0]       strap_i,
    output logic                     sda_oe,
    output logic [NUM_CH*CODE_W-1:0] chan_code,
    output logic [NUM_CH-1:0]        chan_upd
);

    localparam int LN_SCL = 0;
    localparam int LN_SDA = 1;

    logic [1:0]        ln_lvl, ln_rise, ln_fall;
    logic              scl_rise, scl_fall, bus_start, bus_stop, bus_evt;
    logic              byte_vld, frame_rst;
    logic [CODE_W-1:0] byte_data;

    dacs_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  ({sda_i, scl_i}),
        .lvl_o  (ln_lvl),
        .rise_o (ln_rise),
        .fall_o (ln_fall)
    );

    assign scl_rise  = ln_rise[LN_SCL];
    assign scl_fall  = ln_fall[LN_SCL];
    assign bus_start = ln_lvl[LN_SCL] && !ln_rise[LN_SCL] && ln_fall[LN_SDA];
    assign bus_stop  = ln_lvl[LN_SCL] && !ln_rise[LN_SCL] && ln_rise[LN_SDA];
    assign bus_evt   = bus_start || bus_stop;

    dacs_link #(
        .BYTE_W   (CODE_W),
        .PREFIX_W (PREFIX_W),
        .PREFIX   (PREFIX),
        .STRAP_W  (STRAP_W)
    ) u_link (
        .clk       (clk),
        .rst       (rst),
        .sda_lvl   (ln_lvl[LN_SDA]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .strap_i   (strap_i),
        .sda_oe    (sda_oe),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .frame_rst (frame_rst)
    );

    dacs_regs #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .frame_rst (frame_rst),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .chan_code (chan_code),
        .chan_upd  (chan_upd)
    );

endmodule

// File: rtl/dacs_chk.sv
module dacs_chk #(
    parameter int NUM_CH = 2,
    parameter int CODE_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     sda_oe,
    input logic [NUM_CH*CODE_W-1:0] chan_code,
    input logic [NUM_CH-1:0]        chan_upd,
    input logic                     scl_fall,
    input logic                     bus_evt
);

    // R4
    oe_rise_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(scl_fall));

    // R4
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) |-> ($past(scl_fall) || $past(bus_evt)));

    // R6
    upd_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_upd));

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            // R6
            upd_single_chk: assert property (@(posedge clk) disable iff (rst)
                chan_upd[g] |=> !chan_upd[g]);
            // R6
            code_needs_upd_chk: assert property (@(posedge clk) disable iff (rst)
                (chan_code[g*CODE_W +: CODE_W] != $past(chan_code[g*CODE_W +: CODE_W]))
                |-> chan_upd[g]);
        end
    endgenerate

endmodule

bind dac_bus_slave dacs_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_oe    (sda_oe),
    .chan_code (chan_code),
    .chan_upd  (chan_upd),
    .scl_fall  (scl_fall),
    .bus_evt   (bus_evt)
);

// File: tb/dac_bus_slave_test.sv
module dac_bus_slave_test;

    localparam int H = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_drv = 1'b1;
    logic        sda_drv = 1'b1;
    logic [1:0]  strap = 2'd0;
    logic        sda_oe;
    logic [15:0] chan_code;
    logic [1:0]  chan_upd;
    logic        sda_line;

    int n_cmp = 0;
    int n_bad = 0;
    int upd_cnt [2];
    logic [7:0] exp_code [2];

    always #2 clk = ~clk;

    assign sda_line = sda_drv & ~sda_oe;

    dac_bus_slave uut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_drv),
        .sda_i     (sda_line),
        .strap_i   (strap),
        .sda_oe    (sda_oe),
        .chan_code (chan_code),
        .chan_upd  (chan_upd)
    );

    always @(negedge clk) begin
        if (rst) begin
            upd_cnt[0] <= 0;
            upd_cnt[1] <= 0;
        end else begin
            if (chan_upd[0]) upd_cnt[0] <= upd_cnt[0] + 1;
            if (chan_upd[1]) upd_cnt[1] <= upd_cnt[1] + 1;
        end
    end

    // {strap, address byte, selector byte, value byte, address accepted}
    localparam logic [26:0] VECS [8] = '{
        {2'd0, 8'h58, 8'h00, 8'h3C, 1'b1},
        {2'd0, 8'h58, 8'h01, 8'hA5, 1'b1},
        {2'd1, 8'h5A, 8'hFE, 8'h11, 1'b1},
        {2'd1, 8'h58, 8'h01, 8'h77, 1'b0},
        {2'd2, 8'h5D, 8'h00, 8'h99, 1'b0},
        {2'd3, 8'h5E, 8'h03, 8'hFF, 1'b1},
        {2'd3, 8'h5C, 8'h00, 8'h22, 1'b0},
        {2'd2, 8'h5C, 8'h80, 8'h00, 1'b1}
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        wait_cyc(H/2); sda_drv = 1'b1;
        wait_cyc(H/2); scl_drv = 1'b1;
        wait_cyc(H);   sda_drv = 1'b0;
        wait_cyc(H);   scl_drv = 1'b0;
    endtask

    task automatic bus_stop();
        wait_cyc(H/2); sda_drv = 1'b0;
        wait_cyc(H/2); scl_drv = 1'b1;
        wait_cyc(H);   sda_drv = 1'b1;
        wait_cyc(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic pre;
        for (int i = 7; i >= 0; i--) begin
            wait_cyc(H/2); sda_drv = b[i];
            wait_cyc(H/2); scl_drv = 1'b1;
            wait_cyc(H/2);
            if (i == 0) pre = sda_oe;
            wait_cyc(H/2); scl_drv = 1'b0;
        end
        wait_cyc(H/2); sda_drv = 1'b1;
        wait_cyc(H/2); scl_drv = 1'b1;
        wait_cyc(H/2); acked = sda_oe;
        wait_cyc(H/2); scl_drv = 1'b0;
        wait_cyc(H/2);
        chk("R4 oe low during bits", {31'd0, pre}, 32'd0);
        chk("R4 oe released after ninth clock", {31'd0, sda_oe}, 32'd0);
    endtask

    task automatic check_codes(input string tag);
        chk({tag, " ch0 code"}, {24'd0, chan_code[7:0]}, {24'd0, exp_code[0]});
        chk({tag, " ch1 code"}, {24'd0, chan_code[15:8]}, {24'd0, exp_code[1]});
    endtask

    initial begin
        int   b0, b1;
        logic a;

        exp_code[0] = 8'h00;
        exp_code[1] = 8'h00;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(5);

        // R1 reset state
        check_codes("R1");
        chk("R1 oe after reset", {31'd0, sda_oe}, 32'd0);
        chk("R1 no strobes", upd_cnt[0] + upd_cnt[1], 32'd0);

        // Vector walk: R2, R3, R5, R6
        for (int v = 0; v < 8; v++) begin
            logic [7:0] ad, sel, val;
            logic       ok;
            int         ch;
            strap = VECS[v][26:25];
            ad    = VECS[v][24:17];
            sel   = VECS[v][16:9];
            val   = VECS[v][8:1];
            ok    = VECS[v][0];
            ch    = int'(sel[0]);
            wait_cyc(4);
            b0 = upd_cnt[0]; b1 = upd_cnt[1];
            bus_start();
            send_byte(ad, a);
            chk(ok ? "R2 address ack" : "R3 address nack", {31'd0, a}, {31'd0, ok});
            send_byte(sel, a);
            chk(ok ? "R2 selector ack" : "R3 selector ignored", {31'd0, a}, {31'd0, ok});
            send_byte(val, a);
            chk(ok ? "R2 value ack" : "R3 value ignored", {31'd0, a}, {31'd0, ok});
            bus_stop();
            if (ok) exp_code[ch] = val;
            check_codes(ok ? "R5" : "R3");
            chk("R6 ch0 strobe count", upd_cnt[0] - b0, (ok && ch == 0) ? 32'd1 : 32'd0);
            chk("R6 ch1 strobe count", upd_cnt[1] - b1, (ok && ch == 1) ? 32'd1 : 32'd0);
        end

        // R7: several pairs in one transaction
        strap = 2'd1;
        wait_cyc(4);
        b0 = upd_cnt[0]; b1 = upd_cnt[1];
        bus_start();
        send_byte(8'h5A, a);
        send_byte(8'h00, a); send_byte(8'h10, a);
        send_byte(8'h01, a); send_byte(8'h20, a);
        send_byte(8'h00, a); send_byte(8'h30, a);
        chk("R7 last value ack", {31'd0, a}, 32'd1);
        bus_stop();
        exp_code[0] = 8'h30; exp_code[1] = 8'h20;
        check_codes("R7");
        chk("R7 ch0 strobes", upd_cnt[0] - b0, 32'd2);
        chk("R7 ch1 strobes", upd_cnt[1] - b1, 32'd1);

        // R8: repeated START drops the pending selector, next byte is an address
        b0 = upd_cnt[0]; b1 = upd_cnt[1];
        bus_start();
        send_byte(8'h5A, a);
        send_byte(8'h01, a);
        bus_start();
        send_byte(8'h44, a);
        chk("R8 byte after restart taken as address", {31'd0, a}, 32'd0);
        bus_start();
        send_byte(8'h5A, a);
        chk("R8 address after restart", {31'd0, a}, 32'd1);
        send_byte(8'h00, a); send_byte(8'h44, a);
        bus_stop();
        exp_code[0] = 8'h44;
        check_codes("R8");
        chk("R8 ch1 untouched", upd_cnt[1] - b1, 32'd0);
        chk("R8 ch0 one write", upd_cnt[0] - b0, 32'd1);

        // R9: STOP after selector discards it
        bus_start();
        send_byte(8'h5A, a);
        send_byte(8'h00, a);
        bus_stop();
        check_codes("R9 after cut pair");
        bus_start();
        send_byte(8'h5A, a);
        send_byte(8'hAB, a); send_byte(8'h12, a);
        bus_stop();
        exp_code[1] = 8'h12;
        check_codes("R9");

        // R1: reset in mid-run clears codes
        wait_cyc(3);
        rst = 1'b1;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(2);
        exp_code[0] = 8'h00; exp_code[1] = 8'h00;
        check_codes("R1 rerun");
        chk("R1 oe rerun", {31'd0, sda_oe}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait_cyc(150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule